// File: doc/BRIEF.md
# Adaptive Linear Harmonic Estimator Channel

This block is one estimation channel of an adaptive linear combiner that tracks the Fourier content of a sampled grid signal. It keeps a weight for the dc level and one sine weight and one cosine weight for each harmonic. Once per base period of a shared reference generator it builds the estimated sample from those weights and the reference stream. It then takes the error against the measured 12-bit sample and corrects every weight by the least-mean-square (Widrow–Hoff) rule. The step size is a power of two, so the step is applied as an arithmetic right shift.

The reference generator drives its 2N sine and cosine values one at a time over a shared bus. A voltage channel and a current channel can each hold their own copy of this block and read the same stream. All products go through a single signed multiplier: first the weight-by-reference products for the estimate, then the error-by-reference products for the update. The reference values seen during the estimate are kept so that the update uses the same values. A controller steers the multiplier, and a one-cycle strobe reports when the estimate, the error and every new weight are ready. Software or a supervising block can read any weight through an index port.

Top module: `adaline_chan`

## Requirements
- R1: During and after reset, every weight reads zero, `estOut` and `errOut` are zero, and `busy` and `done` are low.
- R2: `start` sampled high while idle latches `sampleIn` and `stepShift` for the whole base period. Later changes to those inputs have no effect. A `start` that arrives while `busy` is high is ignored.
- R3: Weights are signed 16-bit values with 4 fractional bits. References are signed 12-bit values with 10 fractional bits. The k-th valid reference after `start` is reference index k (0..2N-1). The estimate is floor((W_dc·1024 + Σ W_k·X_k) / 2^14), clamped to the signed 12-bit range, and it is computed with the weights held before this period's update.
- R4: `errOut` (signed 13-bit) equals the latched sample minus `estOut`.
- R5: Each harmonic weight k becomes W_k + floor(err·X_k / 2^(6+s)), where s is the latched step shift and X_k is the reference captured in the same period.
- R6: The dc weight, read at index 2N, becomes W_dc + floor(err·16 / 2^s).
- R7: Every weight update saturates at the signed 16-bit limits −32768 and 32767 and does not wrap.
- R8: `busy` rises in the cycle after `start` is accepted. `done` is a single-cycle pulse 4N+2 cycles after the `start` edge when the references arrive back to back. Each cycle in which `refValid` is low during collection adds one cycle. `busy` falls in the same cycle that `done` rises.
- R9: `refValid` and `refData` outside the collection of the 2N references have no effect on the weights, the estimate or the error.
- R10: `rdWeight` shows weight `rdIdx` combinationally, with index 2N for the dc weight. Any index above 2N reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a base period (accepted only when idle) |
| sampleIn | input | 12 | Signed ADC sample |
| stepShift | input | 3 | Step size exponent s, step = 2^-s |
| refValid | input | 1 | Reference value on `refData` is valid |
| refData | input | 12 | Signed reference value, 10 fractional bits |
| rdIdx | input | 4 | Weight read index |
| rdWeight | output | 16 | Selected weight, 4 fractional bits |
| estOut | output | 12 | Estimated sample of the last period |
| errOut | output | 13 | Estimation error of the last period |
| busy | output | 1 | Base period in progress |
| done | output | 1 | One-cycle strobe: results and weights updated |

## Verification
With N = 4 harmonics, `busy` is due one cycle after the accepted `start` edge, and `done`, `estOut` and `errOut` are due 18 cycles after it, plus one cycle for each gap inserted in the reference stream. The new weights can be read through `rdWeight` in the same cycle as `done`. The driver records the cycle in which `start` was taken and pushes the expected estimate, error and latency into a queue. The monitor pops one entry on every `done` seen at a falling edge and checks the latency as a cycle count, so a result that arrives one cycle early or late is caught. Weights are read back at falling edges after `done`, with no clock edge involved, and compared with a bench model of the fixed-point rules above.

// File: rtl/adaline_pkg.sv
package adaline_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_EST,
    ST_UPD
  } chanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // accept sample, seed accumulator with dc term
    logic accEn;    // accumulate one weight*reference product
    logic estEn;    // register estimate and error
    logic updEn;    // write one updated weight
    logic lastUpd;  // final weight (dc) being written
  } chanCtl_t;

endpackage

// File: rtl/adaline_ctrl.sv
module adaline_ctrl
  import adaline_pkg::*;
#(
  parameter int NREF = 8,
  localparam int NW = NREF + 1,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          refValid,
  output chanCtl_t      ctl,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);

  localparam logic [IW-1:0] LAST_REF = IW'(NREF - 1);
  localparam logic [IW-1:0] LAST_W   = IW'(NREF);

  chanState_e state;

  always_comb begin
    ctl.load    = (state == ST_IDLE) && start;
    ctl.accEn   = (state == ST_ACC) && refValid;
    ctl.estEn   = (state == ST_EST);
    ctl.updEn   = (state == ST_UPD);
    ctl.lastUpd = (state == ST_UPD) && (idx == LAST_W);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.lastUpd;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ACC;
            idx   <= '0;
          end
        end
        ST_ACC: begin
          if (refValid) begin
            if (idx == LAST_REF) begin
              state <= ST_EST;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_EST: begin
          state <= ST_UPD;
          idx   <= '0;
        end
        ST_UPD: begin
          if (idx == LAST_W) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adaline_dpath.sv
module adaline_dpath
  import adaline_pkg::*;
#(
  parameter int NREF  = 8,
  parameter int SW    = 12,
  parameter int XW    = 12,
  parameter int XFRAC = 10,
  parameter int WW    = 16,
  parameter int WFRAC = 4,
  parameter int SHW   = 3,
  localparam int NW = NREF + 1,
  localparam int IW = $clog2(NW),
  localparam int EW = SW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chanCtl_t             ctl,
  input  logic [IW-1:0]        idx,
  input  logic signed [SW-1:0] sampleIn,
  input  logic [SHW-1:0]       stepShift,
  input  logic signed [XW-1:0] refData,
  input  logic [IW-1:0]        rdIdx,
  output logic signed [WW-1:0] rdWeight,
  output logic signed [SW-1:0] estOut,
  output logic signed [EW-1:0] errOut
);

  localparam int PW  = WW + XW;
  localparam int AW  = PW + IW + 1;
  localparam int ESH = WFRAC + XFRAC;
  localparam int USH = XFRAC - WFRAC;

  localparam logic signed [XW-1:0]   X_ONE = XW'(2 ** XFRAC);
  localparam logic signed [AW-1:0]   EMAX  = AW'(2 ** (SW - 1) - 1);
  localparam logic signed [AW-1:0]   EMIN  = AW'(-(2 ** (SW - 1)));
  localparam logic signed [PW:0]     WMAX  = (PW + 1)'(2 ** (WW - 1) - 1);
  localparam logic signed [PW:0]     WMIN  = (PW + 1)'(-(2 ** (WW - 1)));

  logic signed [SW-1:0]  sampleQ;
  logic [SHW-1:0]        shiftQ;
  logic signed [AW-1:0]  accQ;
  logic signed [WW-1:0]  wReg [NW];
  logic signed [XW-1:0]  xReg [NREF];
  logic signed [SW-1:0]  estQ;
  logic signed [EW-1:0]  errQ;

  logic signed [WW-1:0]  wSel;
  logic signed [XW-1:0]  xSel;
  logic signed [WW-1:0]  opA;
  logic signed [XW-1:0]  opB;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  delta;
  logic signed [PW:0]    wSum;
  logic signed [WW-1:0]  wNext;
  logic signed [AW-1:0]  accShift;
  logic signed [SW-1:0]  estNext;
  logic signed [EW-1:0]  errNext;

  // operand selection for the one shared multiplier
  always_comb begin
    wSel = '0;
    for (int k = 0; k < NW; k++) begin
      if (idx == IW'(k)) wSel = wReg[k];
    end
  end

  always_comb begin
    xSel = X_ONE;
    for (int k = 0; k < NREF; k++) begin
      if (idx == IW'(k)) xSel = xReg[k];
    end
  end

  assign opA  = ctl.updEn ? WW'(errQ) : wSel;
  assign opB  = ctl.updEn ? xSel : refData;
  assign prod = opA * opB;

  // weight update with saturation
  assign delta = prod >>> (USH + int'(shiftQ));
  assign wSum  = (PW + 1)'(wSel) + (PW + 1)'(delta);

  always_comb begin
    if (wSum > WMAX)      wNext = WW'(WMAX);
    else if (wSum < WMIN) wNext = WW'(WMIN);
    else                  wNext = WW'(wSum);
  end

  // estimate and error
  assign accShift = accQ >>> ESH;

  always_comb begin
    if (accShift > EMAX)      estNext = SW'(EMAX);
    else if (accShift < EMIN) estNext = SW'(EMIN);
    else                      estNext = SW'(accShift);
  end

  assign errNext = EW'(sampleQ) - EW'(estNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ <= '0;
      shiftQ  <= '0;
      accQ    <= '0;
      estQ    <= '0;
      errQ    <= '0;
      for (int k = 0; k < NW; k++)   wReg[k] <= '0;
      for (int k = 0; k < NREF; k++) xReg[k] <= '0;
    end else begin
      if (ctl.load) begin
        sampleQ <= sampleIn;
        shiftQ  <= stepShift;
        accQ    <= AW'(wReg[NREF]) <<< XFRAC;
      end
      if (ctl.accEn) begin
        accQ <= accQ + AW'(prod);
        for (int k = 0; k < NREF; k++) begin
          if (idx == IW'(k)) xReg[k] <= refData;
        end
      end
      if (ctl.estEn) begin
        estQ <= estNext;
        errQ <= errNext;
      end
      if (ctl.updEn) begin
        for (int k = 0; k < NW; k++) begin
          if (idx == IW'(k)) wReg[k] <= wNext;
        end
      end
    end
  end

  always_comb begin
    rdWeight = '0;
    for (int k = 0; k < NW; k++) begin
      if (rdIdx == IW'(k)) rdWeight = wReg[k];
    end
  end

  assign estOut = estQ;
  assign errOut = errQ;

endmodule

// File: rtl/adaline_chan.sv
module adaline_chan
  import adaline_pkg::*;
#(
  parameter int NH    = 4,
  parameter int SW    = 12,
  parameter int XW    = 12,
  parameter int XFRAC = 10,
  parameter int WW    = 16,
  parameter int WFRAC = 4,
  parameter int SHW   = 3,
  localparam int NREF = 2 * NH,
  localparam int NW   = NREF + 1,
  localparam int IW   = $clog2(NW),
  localparam int EW   = SW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic signed [SW-1:0] sampleIn,
  input  logic [SHW-1:0]       stepShift,
  input  logic                 refValid,
  input  logic signed [XW-1:0] refData,
  input  logic [IW-1:0]        rdIdx,
  output logic signed [WW-1:0] rdWeight,
  output logic signed [SW-1:0] estOut,
  output logic signed [EW-1:0] errOut,
  output logic                 busy,
  output logic                 done
);

  chanCtl_t      ctl;
  logic [IW-1:0] idx;

  adaline_ctrl #(.NREF(NREF)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .refValid (refValid),
    .ctl      (ctl),
    .idx      (idx),
    .busy     (busy),
    .done     (done)
  );

  adaline_dpath #(
    .NREF(NREF), .SW(SW), .XW(XW), .XFRAC(XFRAC),
    .WW(WW), .WFRAC(WFRAC), .SHW(SHW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .idx       (idx),
    .sampleIn  (sampleIn),
    .stepShift (stepShift),
    .refData   (refData),
    .rdIdx     (rdIdx),
    .rdWeight  (rdWeight),
    .estOut    (estOut),
    .errOut    (errOut)
  );

endmodule

// File: rtl/adaline_chan_sva.sv
module adaline_chan_sva #(
  parameter int SW = 12,
  localparam int EW = SW + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic signed [SW-1:0] sampleIn,
  input logic signed [SW-1:0] estOut,
  input logic signed [EW-1:0] errOut
);

  logic signed [SW-1:0] smpHeld;

  always_ff @(posedge clk) begin
    if (!rstN) smpHeld <= '0;
    else if (start && !busy) smpHeld <= sampleIn;
  end

  // R4: reported error matches the sample accepted at start minus the estimate
  assert_err_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errOut == (EW'(smpHeld) - EW'(estOut))));

  // R8: completion strobe lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy ends together with the completion strobe
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: completion only follows a busy period
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R2: results hold while the channel is idle
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> ($stable(estOut) && $stable(errOut)));

endmodule

bind adaline_chan adaline_chan_sva #(.SW(SW)) u_chan_sva (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .sampleIn (sampleIn),
  .estOut   (estOut),
  .errOut   (errOut)
);

// File: tb/adaline_chan_bench.sv
module adaline_chan_bench;

  localparam int NH = 4;
  localparam int NREF = 2 * NH;
  localparam int NW = NREF + 1;
  localparam int BASE_LAT = 4 * NH + 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic signed [11:0] sampleIn;
  logic [2:0]        stepShift;
  logic              refValid;
  logic signed [11:0] refData;
  logic [3:0]        rdIdx;
  logic signed [15:0] rdWeight;
  logic signed [11:0] estOut;
  logic signed [12:0] errOut;
  logic              busy;
  logic              done;

  always #5 clk = ~clk;

  adaline_chan u_adaline_chan (
    .clk(clk), .rstN(rstN), .start(start), .sampleIn(sampleIn),
    .stepShift(stepShift), .refValid(refValid), .refData(refData),
    .rdIdx(rdIdx), .rdWeight(rdWeight), .estOut(estOut), .errOut(errOut),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int startCyc = 0;
  longint mW [NW];

  typedef struct {
    longint est;
    longint err;
    int     lat;
  } expItem_t;

  expItem_t sb[$];

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint satW(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // monitor: compare results as done appears
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        expItem_t it;
        it = sb.pop_front();
        chk("R3", "estimate", longint'(estOut), it.est);
        chk("R4", "error", longint'(errOut), it.err);
        chk("R8", "latency", longint'(cyc - startCyc), longint'(it.lat));
      end
    end
  end

  task automatic checkWeights(string tagX, string tagDc);
    for (int i = 0; i < NREF; i++) begin
      rdIdx = 4'(i);
      #1;
      chk(tagX, "harmonic weight", longint'(rdWeight), mW[i]);
    end
    rdIdx = 4'(NREF);
    #1;
    chk(tagDc, "dc weight", longint'(rdWeight), mW[NREF]);
    rdIdx = 4'(NW);
    #1;
    chk("R10", "index above range", longint'(rdWeight), 0);
    rdIdx = 4'hF;
    #1;
    chk("R10", "top index", longint'(rdWeight), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    start = 1'b0;
    refValid = 1'b0;
    refData = '0;
    sampleIn = '0;
    stepShift = '0;
    rdIdx = '0;
    for (int i = 0; i < NW; i++) mW[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", longint'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", longint'(busy), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "estOut", longint'(estOut), 0);
    chk("R1", "errOut", longint'(errOut), 0);
    checkWeights("R1", "R1");
  endtask

  // driver: model the period, push expectations, drive the stimulus
  task automatic runPeriod(int smp, int sh, int xs[NREF], int gapAfter, bit junk,
                           string tagX, string tagDc);
    longint acc, est, err;
    expItem_t it;
    acc = mW[NREF] * 1024;
    for (int i = 0; i < NREF; i++) acc += mW[i] * longint'(xs[i]);
    est = acc >>> 14;
    if (est > 2047) est = 2047;
    if (est < -2048) est = -2048;
    err = longint'(smp) - est;
    for (int i = 0; i < NREF; i++)
      mW[i] = satW(mW[i] + ((err * longint'(xs[i])) >>> (6 + sh)));
    mW[NREF] = satW(mW[NREF] + ((err * 1024) >>> (6 + sh)));
    it.est = est;
    it.err = err;
    it.lat = BASE_LAT + ((gapAfter >= 0) ? 1 : 0);
    sb.push_back(it);

    @(negedge clk);
    start = 1'b1;
    sampleIn = 12'(smp);
    stepShift = 3'(sh);
    startCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    sampleIn = 12'sh5A5;
    stepShift = 3'd7;
    chk("R8", "busy after start", longint'(busy), 1);
    for (int i = 0; i < NREF; i++) begin
      refValid = 1'b1;
      refData = 12'(xs[i]);
      @(negedge clk);
      if (i == gapAfter) begin
        refValid = 1'b0;
        refData = 12'sd999;
        @(negedge clk);
      end
    end
    refValid = 1'b0;
    if (junk) begin
      // R2 and R9: start and references while busy must be ignored
      refValid = 1'b1;
      refData = 12'sd777;
      start = 1'b1;
      sampleIn = -12'sd1000;
      repeat (3) @(negedge clk);
      refValid = 1'b0;
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    checkWeights(tagX, tagDc);
    @(negedge clk);
    chk("R8", "busy after done", longint'(busy), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int xa [NREF] = '{1023, 0, 724, 724, 0, -1023, -724, 724};
    int xb [NREF] = '{-300, 950, 512, -512, 1000, 100, -800, 400};
    int xc [NREF] = '{0, 0, 0, 0, 0, 0, 0, 0};
    int xp [NREF] = '{1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023};
    int xm [NREF] = '{1023, 1023, 1023, 1023, -1023, -1023, -1023, -1023};

    doReset();
    runPeriod(1000, 2, xa, -1, 1'b0, "R5", "R6");
    runPeriod(-500, 3, xb, 3, 1'b0, "R5", "R6");
    runPeriod(1500, 1, xa, -1, 1'b1, "R9", "R2");
    runPeriod(700, 4, xc, -1, 1'b0, "R5", "R6");
    runPeriod(-1200, 0, xb, 6, 1'b1, "R9", "R2");
    runPeriod(333, 5, xa, -1, 1'b0, "R5", "R6");

    // saturation: drive weights past both limits from a clean state
    doReset();
    runPeriod(2047, 0, xp, -1, 1'b0, "R5", "R6");
    runPeriod(-2048, 0, xm, -1, 1'b0, "R7", "R7");
    runPeriod(2047, 0, xm, -1, 1'b0, "R7", "R7");

    repeat (3) @(negedge clk);
    chk("R8", "scoreboard drained", longint'(sb.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule